// File: doc/BRIEF.md
# Interface Identifier to Unit Translator

This block performs the translate step of an overloadable-command scheme. Software loads an operand whose upper bits name an extension interface and whose low 12 bits give a device sequence number. A device number of zero asks for the default implementation of that interface. The block looks this key up, together with the current one-hot privilege level, in an associative table that is written at boot. It returns a word with the matched 12-bit logical unit number in its low bits. The upper bits of that word carry the low bits of a second data operand, so the result can feed a later command directly.

The lookup keeps no state between requests. It allocates nothing and initialises no device. When no entry matches, the opcode variant picks one of three fixed fallback unit numbers: trap, return-zero or return-all-ones. Identifiers 0, 1 and 2 with device number 0 are built into the block and always resolve to units 0, 1 and 2 at any legal privilege. The result is registered, and a valid strobe comes out one cycle after the request.

Top module: `ifid_unit_xlate`

## Requirements
- R1: After reset `rsp_valid` and `rsp_word` are 0 and every table entry is invalid, so any lookup that is not built in misses.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. It is low in every other cycle.
- R3: `rsp_word[11:0]` is the resolved unit number. `rsp_word[XLEN-1:12]` equals `req_data[XLEN-13:0]` of the same request.
- R4: A valid table entry hits only when its identifier equals `req_key[XLEN-1:12]`, its device number equals `req_key[11:0]`, and its privilege equals `req_priv`. Privilege codes are user 4'b0001, supervisor 4'b0010, hypervisor 4'b0100 and machine 4'b1000.
- R5: On a miss the unit number depends on `req_variant`: 2'd0 gives 0, 2'd1 gives 1, 2'd2 gives 2, and the reserved code 2'd3 gives 0.
- R6: When several valid entries hit, the one with the lowest index supplies the unit number.
- R7: Identifier 0, 1 or 2 with device number 0 and a one-hot `req_priv` resolves to the unit equal to the identifier, whatever the table holds. A privilege that is not one-hot does not resolve this way.
- R8: A table write takes effect for requests from the next cycle on. A request in the same cycle as the write sees the old contents. Writing an entry with `prog_vld` low removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Table write enable |
| prog_idx | input | IDX_W | Entry index to write |
| prog_vld | input | 1 | Valid bit written into the entry |
| prog_ident | input | XLEN-12 | Interface identifier of the entry |
| prog_dev | input | 12 | Device sequence number of the entry |
| prog_priv | input | 4 | One-hot privilege of the entry |
| prog_unit | input | 12 | Unit number returned on a hit |
| req_valid | input | 1 | Translate request strobe |
| req_key | input | XLEN | Identifier (upper bits) and device number (bits 11:0) |
| req_data | input | XLEN | Data operand, low XLEN-12 bits are forwarded |
| req_priv | input | 4 | Current one-hot privilege level |
| req_variant | input | 2 | Miss behaviour: 0 trap, 1 zero, 2 all-ones, 3 reserved |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_word | output | XLEN | Packed result: data bits above, unit number below |

## Verification
The bench first goes after key fields that nearly match. It checks that the same identifier under a different device number or privilege misses, and that the lookup stays silent rather than picking up a neighbouring entry. A design that compared only part of the key would return the wrong unit. It then stacks duplicate keys to catch a priority encoder that favours the highest index, and it issues a request in the same cycle as a table write, which a design with write-through would answer with the new unit. It also places a table entry over a built-in identifier and uses a non-one-hot privilege against the built-ins, so that a table entry is caught overriding a reserved mapping and a loose privilege test is caught accepting an illegal level.

// File: rtl/xl_pkg.sv
package xl_pkg;
   localparam int UNIT_W = 12;
   localparam int PRIV_W = 4;
   localparam int N_BUILTIN = 3;

   typedef enum logic [1:0] {
      XV_TRAP = 2'd0,
      XV_ZERO = 2'd1,
      XV_ONES = 2'd2,
      XV_RSVD = 2'd3
   } miss_variant_e;

   localparam logic [PRIV_W-1:0] PRV_USER  = 4'b0001;
   localparam logic [PRIV_W-1:0] PRV_SUPER = 4'b0010;
   localparam logic [PRIV_W-1:0] PRV_HYPER = 4'b0100;
   localparam logic [PRIV_W-1:0] PRV_MACH  = 4'b1000;

   function automatic logic [UNIT_W-1:0] miss_unit(input logic [1:0] v);
      case (v)
         XV_ZERO: miss_unit = UNIT_W'(1);
         XV_ONES: miss_unit = UNIT_W'(2);
         default: miss_unit = '0;
      endcase
   endfunction
endpackage

// File: rtl/xl_table.sv
module xl_table
   import xl_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int ID_W    = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [IDX_W-1:0]                  idx,
   input  logic                              vld_in,
   input  logic [ID_W-1:0]                   id_in,
   input  logic [UNIT_W-1:0]                 dev_in,
   input  logic [PRIV_W-1:0]                 priv_in,
   input  logic [UNIT_W-1:0]                 unit_in,
   output logic [ENTRIES-1:0]                ent_vld,
   output logic [ENTRIES-1:0][ID_W-1:0]      ent_id,
   output logic [ENTRIES-1:0][UNIT_W-1:0]    ent_dev,
   output logic [ENTRIES-1:0][PRIV_W-1:0]    ent_priv,
   output logic [ENTRIES-1:0][UNIT_W-1:0]    ent_unit
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic sel;
      assign sel = we && (idx == IDX_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_vld[e]  <= 1'b0;
            ent_id[e]   <= '0;
            ent_dev[e]  <= '0;
            ent_priv[e] <= '0;
            ent_unit[e] <= '0;
         end else if (sel) begin
            ent_vld[e]  <= vld_in;
            ent_id[e]   <= id_in;
            ent_dev[e]  <= dev_in;
            ent_priv[e] <= priv_in;
            ent_unit[e] <= unit_in;
         end
      end
   end
endmodule

// File: rtl/xl_match.sv
module xl_match
   import xl_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int ID_W    = 20
) (
   input  logic [ENTRIES-1:0]                ent_vld,
   input  logic [ENTRIES-1:0][ID_W-1:0]      ent_id,
   input  logic [ENTRIES-1:0][UNIT_W-1:0]    ent_dev,
   input  logic [ENTRIES-1:0][PRIV_W-1:0]    ent_priv,
   input  logic [ENTRIES-1:0][UNIT_W-1:0]    ent_unit,
   input  logic [ID_W-1:0]                   key_id,
   input  logic [UNIT_W-1:0]                 key_dev,
   input  logic [PRIV_W-1:0]                 key_priv,
   output logic                              hit,
   output logic [UNIT_W-1:0]                 hit_unit
);
   logic [ENTRIES-1:0] hv;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hv[e] = ent_vld[e] && (ent_id[e] == key_id) &&
                     (ent_dev[e] == key_dev) && (ent_priv[e] == key_priv);
   end

   // scan downward so the lowest matching index is the last one assigned
   always_comb begin
      hit_unit = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (hv[e]) hit_unit = ent_unit[e];
      end
   end

   assign hit = |hv;
endmodule

// File: rtl/ifid_unit_xlate.sv
module ifid_unit_xlate
   import xl_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int ENTRIES = 8,
   parameter bit BUILTIN = 1'b1,
   localparam int ID_W   = XLEN - UNIT_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prog_we,
   input  logic [IDX_W-1:0]   prog_idx,
   input  logic               prog_vld,
   input  logic [ID_W-1:0]    prog_ident,
   input  logic [UNIT_W-1:0]  prog_dev,
   input  logic [PRIV_W-1:0]  prog_priv,
   input  logic [UNIT_W-1:0]  prog_unit,
   input  logic               req_valid,
   input  logic [XLEN-1:0]    req_key,
   input  logic [XLEN-1:0]    req_data,
   input  logic [PRIV_W-1:0]  req_priv,
   input  logic [1:0]         req_variant,
   output logic               rsp_valid,
   output logic [XLEN-1:0]    rsp_word
);
   if (XLEN < 32) begin : g_bad_xlen
      $error("ifid_unit_xlate: XLEN must be at least 32");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("ifid_unit_xlate: ENTRIES must be at least 2");
   end

   logic [ENTRIES-1:0]             t_vld;
   logic [ENTRIES-1:0][ID_W-1:0]   t_id;
   logic [ENTRIES-1:0][UNIT_W-1:0] t_dev;
   logic [ENTRIES-1:0][PRIV_W-1:0] t_priv;
   logic [ENTRIES-1:0][UNIT_W-1:0] t_unit;

   xl_table #(.ENTRIES(ENTRIES), .ID_W(ID_W)) u_table (
      .clk(clk), .rst_n(rst_n), .we(prog_we), .idx(prog_idx),
      .vld_in(prog_vld), .id_in(prog_ident), .dev_in(prog_dev),
      .priv_in(prog_priv), .unit_in(prog_unit),
      .ent_vld(t_vld), .ent_id(t_id), .ent_dev(t_dev),
      .ent_priv(t_priv), .ent_unit(t_unit)
   );

   logic [ID_W-1:0]   k_id;
   logic [UNIT_W-1:0] k_dev;
   logic              tbl_hit;
   logic [UNIT_W-1:0] tbl_unit;

   assign k_id  = req_key[XLEN-1:UNIT_W];
   assign k_dev = req_key[UNIT_W-1:0];

   xl_match #(.ENTRIES(ENTRIES), .ID_W(ID_W)) u_match (
      .ent_vld(t_vld), .ent_id(t_id), .ent_dev(t_dev),
      .ent_priv(t_priv), .ent_unit(t_unit),
      .key_id(k_id), .key_dev(k_dev), .key_priv(req_priv),
      .hit(tbl_hit), .hit_unit(tbl_unit)
   );

   logic              fix_hit;
   logic [UNIT_W-1:0] fix_unit;

   if (BUILTIN) begin : g_fixed
      assign fix_hit  = (k_id < ID_W'(N_BUILTIN)) && (k_dev == '0) && $onehot(req_priv);
      assign fix_unit = k_id[UNIT_W-1:0];
   end else begin : g_nofixed
      assign fix_hit  = 1'b0;
      assign fix_unit = '0;
   end

   logic [UNIT_W-1:0] sel_unit;
   always_comb begin
      if (fix_hit)      sel_unit = fix_unit;
      else if (tbl_hit) sel_unit = tbl_unit;
      else              sel_unit = miss_unit(req_variant);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_word  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) rsp_word <= {req_data[ID_W-1:0], sel_unit};
      end
   end
endmodule

// File: rtl/xl_chk.sv
module xl_chk
   import xl_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [XLEN-1:0]   req_key,
   input logic [XLEN-1:0]   req_data,
   input logic [PRIV_W-1:0] req_priv,
   input logic              rsp_valid,
   input logic [XLEN-1:0]   rsp_word
);
   localparam int ID_W = XLEN - UNIT_W;

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R2
   AST_DATA_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_word[XLEN-1:UNIT_W] == $past(req_data[ID_W-1:0])); // R3
   AST_BUILTIN_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_key[XLEN-1:UNIT_W] < ID_W'(N_BUILTIN) &&
       req_key[UNIT_W-1:0] == '0 && $onehot(req_priv))
      |=> rsp_word[UNIT_W-1:0] == UNIT_W'($past(req_key[XLEN-1:UNIT_W]))); // R7
endmodule

bind ifid_unit_xlate xl_chk #(.XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_key(req_key),
   .req_data(req_data), .req_priv(req_priv), .rsp_valid(rsp_valid),
   .rsp_word(rsp_word)
);

// File: tb/ifid_unit_xlate_tb_top.sv
module ifid_unit_xlate_tb_top;
   localparam int XLEN = 32;
   localparam int ENT  = 8;
   localparam int IW   = XLEN - 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            prog_we = 0, prog_vld = 0;
   logic [2:0]      prog_idx = 0;
   logic [IW-1:0]   prog_ident = 0;
   logic [11:0]     prog_dev = 0, prog_unit = 0;
   logic [3:0]      prog_priv = 0;
   logic            req_valid = 0;
   logic [XLEN-1:0] req_key = 0, req_data = 0;
   logic [3:0]      req_priv = 0;
   logic [1:0]      req_variant = 0;
   logic            rsp_valid;
   logic [XLEN-1:0] rsp_word;

   ifid_unit_xlate #(.XLEN(XLEN), .ENTRIES(ENT)) dut_i (.*);

   // behavioural reference table
   bit          m_v[ENT];
   int unsigned m_id[ENT], m_dev[ENT], m_pr[ENT], m_un[ENT];
   logic            exp_v = 0;
   logic [XLEN-1:0] exp_w = 0;
   int n_vec = 0, n_bad = 0;
   string tag = "R1";

   function automatic int unsigned ref_unit(int unsigned id, int unsigned dev,
                                            int unsigned pr, int unsigned vr);
      int pc = 0;
      for (int b = 0; b < 4; b++) if (pr[b]) pc++;
      if (id < 3 && dev == 0 && pc == 1) return id;
      for (int e = 0; e < ENT; e++)
         if (m_v[e] && m_id[e] == id && m_dev[e] == dev && m_pr[e] == pr) return m_un[e];
      return (vr == 1) ? 1 : (vr == 2) ? 2 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_v = 0; exp_w = 0;
         for (int e = 0; e < ENT; e++) m_v[e] = 0;
      end else begin
         exp_v = req_valid;
         if (req_valid)
            exp_w = {req_data[IW-1:0],
                     12'(ref_unit(req_key[XLEN-1:12], req_key[11:0], req_priv, req_variant))};
         if (prog_we) begin
            m_v[prog_idx] = prog_vld;   m_id[prog_idx] = prog_ident;
            m_dev[prog_idx] = prog_dev; m_pr[prog_idx] = prog_priv;
            m_un[prog_idx] = prog_unit;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_vec++;
         if (rsp_valid !== exp_v || rsp_word !== exp_w) begin
            n_bad++;
            $display("FAIL %s: rsp_valid=%0b rsp_word=%h expected valid=%0b word=%h",
                     tag, rsp_valid, rsp_word, exp_v, exp_w);
         end
      end
   end

   task automatic idle();
      @(negedge clk); #1;
      prog_we = 0; req_valid = 0;
   endtask

   task automatic prog(input int idx, input bit v, input int unsigned id,
                       input int unsigned dev, input logic [3:0] pr, input int unsigned un,
                       input bit with_req = 0);
      @(negedge clk); #1;
      prog_we = 1; prog_idx = 3'(idx); prog_vld = v; prog_ident = IW'(id);
      prog_dev = 12'(dev); prog_priv = pr; prog_unit = 12'(un);
      if (!with_req) req_valid = 0;
   endtask

   task automatic req(input int unsigned id, input int unsigned dev, input logic [3:0] pr,
                      input int unsigned vr, input logic [XLEN-1:0] d);
      @(negedge clk); #1;
      prog_we = 0; req_valid = 1;
      req_key = {IW'(id), 12'(dev)}; req_priv = pr; req_variant = 2'(vr); req_data = d;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      #1;
      // R1: outputs clear straight after reset
      n_vec++;
      if (rsp_valid !== 0 || rsp_word !== 0) begin
         n_bad++;
         $display("FAIL R1: rsp_valid=%0b rsp_word=%h expected 0 0", rsp_valid, rsp_word);
      end
      tag = "R1"; req(5, 0, 4'b0001, 0, 32'hFFFF_FFFF); idle();
      tag = "R5";
      for (int v = 0; v < 4; v++) req(32'h4242, 0, 4'b0010, v, 32'h1234_5678);
      idle(); idle();
      tag = "R3";
      req(9, 3, 4'b1000, 2, 32'hA5A5_5A5A); req(9, 3, 4'b1000, 1, 32'h0000_0000);
      req(9, 3, 4'b1000, 0, 32'hDEAD_BEEF); idle();
      tag = "R4";
      prog(0, 1, 32'hABCDE, 0, 4'b0010, 34);
      prog(1, 1, 32'hABCDE, 1, 4'b0010, 32);
      prog(2, 1, 32'hABCDE, 0, 4'b0001, 32);
      req(32'hABCDE, 0, 4'b0010, 0, 32'h1111_1111);
      req(32'hABCDE, 1, 4'b0010, 0, 32'h2222_2222);
      req(32'hABCDE, 0, 4'b0001, 0, 32'h3333_3333);
      req(32'hABCDE, 0, 4'b1000, 1, 32'h4444_4444);
      req(32'hABCDF, 0, 4'b0010, 2, 32'h5555_5555);
      req(32'hABCDE, 2, 4'b0010, 0, 32'h6666_6666);
      idle();
      tag = "R6";
      prog(5, 1, 32'h12345, 0, 4'b0100, 35);
      prog(3, 1, 32'h12345, 0, 4'b0100, 33);
      req(32'h12345, 0, 4'b0100, 0, 32'h7777_7777);
      tag = "R8";
      prog(3, 0, 32'h12345, 0, 4'b0100, 33);
      req(32'h12345, 0, 4'b0100, 0, 32'h8888_8888);
      // write and request in the same cycle: old contents answer
      prog(6, 1, 32'h777, 2, 4'b0001, 40, 1);
      req_valid = 1; req_key = {IW'(32'h777), 12'd2}; req_priv = 4'b0001; req_variant = 2;
      req(32'h777, 2, 4'b0001, 2, 32'h9999_9999);
      idle();
      tag = "R7";
      prog(4, 1, 1, 0, 4'b0001, 50);
      for (int i = 0; i < 3; i++)
         for (int p = 0; p < 4; p++) req(i, 0, 4'(1 << p), (i + p) % 4, 32'(i * 16 + p));
      req(2, 0, 4'b0011, 1, 32'hCAFE_0001);
      req(1, 0, 4'b0000, 2, 32'hCAFE_0002);
      req(1, 1, 4'b0001, 0, 32'hCAFE_0003);
      idle(); idle();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule